// File: doc/BRIEF.md
# Host-to-Processor Byte Mailbox with Status Flags

This block is a one-byte mailbox in each direction between an external host bus and an on-chip processor bus. The host drops a byte into an inbound register. The processor returns a byte through an outbound register. An 8-bit status byte tells each side what the other has done. Each flag is set or cleared by which side touches which register. No side writes a flag directly, except that the processor may knock down the outbound flag.

The host side is asynchronous to the block clock. Its chip select, strobes and address bit pass through a synchronizer, and each access takes effect once, at the rising edge of its strobe. When the host writes, its address bit is stored as the command/data marker. The inbound-full flag is raised on a host write and drives an interrupt to the processor. The processor clears it by reading the inbound byte. The outbound-full flag is raised when the processor writes the outbound byte and dropped when the host reads it. The processor may also clear it by writing 0 to bit 0 of the status byte. Five status bits are free for software use: the processor writes them and the host only reads them.

Top module: `mbx_hostlink`

## Requirements
- R1: After reset the status byte is 0x00, `cpu_irq` is 0, and a host status read returns 0x00.
- R2: A host write with `host_cs`=1 loads `host_din` into the inbound register for either value of `host_a0`, and sets inbound-full (status bit 1). The processor reads the inbound byte with `cpu_sel`=0.
- R3: Each host write copies `host_a0` into status bit 3. A value of 0 marks data and 1 marks a command.
- R4: A processor read with `cpu_sel`=0 clears inbound-full. `cpu_irq` equals inbound-full.
- R5: If a host write and a processor inbound read act in the same cycle, inbound-full ends at 1.
- R6: A processor write with `cpu_sel`=0 loads the outbound byte and sets outbound-full (status bit 0). A host read with `host_a0`=0 returns the outbound byte and clears outbound-full. A host read with `host_a0`=1 returns the status byte and leaves outbound-full unchanged.
- R7: A processor write with `cpu_sel`=1 sets status bits 7..4 and 2 from the write data. It leaves bits 3 and 1 unchanged. Host accesses never change bits 7..4 and 2.
- R8: In a processor status write, write-data bit 0 = 0 clears outbound-full and bit 0 = 1 leaves it unchanged.
- R9: The processor reads the status byte with `cpu_sel`=1, in the same layout the host sees.
- R10: A strobe acts only on its rising edge while `host_cs`=1. A strobe held high does not act again, and strobes with `host_cs`=0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_cs | input | 1 | Host chip select, active high |
| host_wr | input | 1 | Host write strobe, active high |
| host_rd | input | 1 | Host read strobe, active high |
| host_a0 | input | 1 | Host address bit: 0 data, 1 status/command |
| host_din | input | 8 | Host write data |
| host_dout | output | 8 | Host read data (outbound byte or status) |
| cpu_sel | input | 1 | Processor register select: 0 data, 1 status |
| cpu_we | input | 1 | Processor write enable |
| cpu_re | input | 1 | Processor read enable |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Processor read data (inbound byte or status) |
| cpu_irq | output | 1 | Inbound-full interrupt request |

## Verification
The assertions take three things for granted about the host side. `host_a0` and `host_din` are stable from before a strobe rises until after it has acted. Write and read strobes are never high together. Each strobe stays high, and then low, for longer than the synchronizer depth plus one cycle. The bench drives every host access this way, holding each level for several cycles more than the synchronizer needs. The one exception is the priority test, where the processor read is placed on the exact cycle in which the synchronized write edge acts.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int BYTE_W  = 8;
  localparam int USER_W  = 5;
  localparam int BIT_OBF = 0;
  localparam int BIT_IBF = 1;
  localparam int BIT_CD  = 3;
  typedef logic [BYTE_W-1:0] mbx_byte_t;
  typedef logic [USER_W-1:0] mbx_user_t;
endpackage

// File: rtl/mbx_host_sync.sv
module mbx_host_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic wr,
  input  logic rd,
  input  logic a0,
  output logic wr_ev,
  output logic rd_data_ev,
  output logic a0_s
);
  localparam int NB = 4;

  logic [NB-1:0] chain [STAGES];
  logic [NB-1:0] tail;
  logic          wr_lvl, rd_lvl;
  logic          wr_q, rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
      wr_q <= 1'b0;
      rd_q <= 1'b0;
    end else begin
      chain[0] <= {cs, wr, rd, a0};
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      wr_q <= wr_lvl;
      rd_q <= rd_lvl;
    end
  end

  assign tail       = chain[STAGES-1];
  assign wr_lvl     = tail[3] & tail[2];
  assign rd_lvl     = tail[3] & tail[1];
  assign a0_s       = tail[0];
  assign wr_ev      = wr_lvl & ~wr_q;
  assign rd_data_ev = rd_lvl & ~rd_q & ~tail[0];

  // R10
  wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ev |=> !wr_ev);
  // R10
  rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_ev |=> !rd_data_ev);
endmodule

// File: rtl/mbx_flags.sv
module mbx_flags
  import mbx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      host_wr_ev,
  input  logic      host_a0,
  input  logic      host_rd_ev,
  input  logic      slv_rd_idr,
  input  logic      slv_wr_odr,
  input  logic      slv_wr_sts,
  input  mbx_user_t slv_user,
  input  logic      slv_obf_bit,
  output mbx_byte_t status,
  output logic      ibf
);
  mbx_user_t user_q, user_n;
  logic      cd_q, cd_n, ibf_q, ibf_n, obf_q, obf_n;
  logic      en;

  always_comb begin
    user_n = user_q;
    cd_n   = cd_q;
    ibf_n  = ibf_q;
    obf_n  = obf_q;
    if (slv_wr_sts) user_n = slv_user;
    if (host_wr_ev) begin
      cd_n  = host_a0;
      ibf_n = 1'b1;
    end else if (slv_rd_idr) begin
      ibf_n = 1'b0;
    end
    if (slv_wr_odr) obf_n = 1'b1;
    else if (host_rd_ev || (slv_wr_sts && !slv_obf_bit)) obf_n = 1'b0;
  end

  assign en = slv_wr_sts | host_wr_ev | slv_rd_idr | slv_wr_odr | host_rd_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      user_q <= '0;
      cd_q   <= 1'b0;
      ibf_q  <= 1'b0;
      obf_q  <= 1'b0;
    end else if (en) begin
      user_q <= user_n;
      cd_q   <= cd_n;
      ibf_q  <= ibf_n;
      obf_q  <= obf_n;
    end
  end

  assign status = {user_q[4:1], cd_q, user_q[0], ibf_q, obf_q};
  assign ibf    = ibf_q;

  // R2
  ibf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr_ev |=> status[BIT_IBF]);
  // R3
  cd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr_ev |=> (status[BIT_CD] == $past(host_a0)));
  // R4
  ibf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slv_rd_idr && !host_wr_ev) |=> !status[BIT_IBF]);
  // R6
  obf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slv_wr_odr |=> status[BIT_OBF]);
  // R7
  user_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slv_wr_sts |=> ($stable(status[7:4]) && $stable(status[2])));
  // R8
  obf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slv_wr_sts && slv_obf_bit && !host_rd_ev) |=> $stable(status[BIT_OBF]));
endmodule

// File: rtl/mbx_hostlink.sv
module mbx_hostlink
  import mbx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_cs,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic        host_a0,
  input  logic [7:0]  host_din,
  output logic [7:0]  host_dout,
  input  logic        cpu_sel,
  input  logic        cpu_we,
  input  logic        cpu_re,
  input  logic [7:0]  cpu_wdata,
  output logic [7:0]  cpu_rdata,
  output logic        cpu_irq
);
  logic [1:0] rst_pipe;
  logic       rst_core_n;
  logic       h_wr_ev, h_rd_ev, h_a0_s;
  logic       slv_rd_idr, slv_wr_odr, slv_wr_sts;
  mbx_byte_t  idr_q, idr_n, odr_q, odr_n, status;
  logic       ibf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  mbx_host_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_core_n),
    .cs(host_cs), .wr(host_wr), .rd(host_rd), .a0(host_a0),
    .wr_ev(h_wr_ev), .rd_data_ev(h_rd_ev), .a0_s(h_a0_s)
  );

  assign slv_rd_idr = cpu_re & ~cpu_sel;
  assign slv_wr_odr = cpu_we & ~cpu_sel;
  assign slv_wr_sts = cpu_we &  cpu_sel;

  mbx_flags flags_i (
    .clk(clk), .rst_n(rst_core_n),
    .host_wr_ev(h_wr_ev), .host_a0(h_a0_s), .host_rd_ev(h_rd_ev),
    .slv_rd_idr(slv_rd_idr), .slv_wr_odr(slv_wr_odr), .slv_wr_sts(slv_wr_sts),
    .slv_user({cpu_wdata[7:4], cpu_wdata[2]}), .slv_obf_bit(cpu_wdata[0]),
    .status(status), .ibf(ibf)
  );

  always_comb begin
    idr_n = h_wr_ev    ? host_din  : idr_q;
    odr_n = slv_wr_odr ? cpu_wdata : odr_q;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      idr_q <= '0;
      odr_q <= '0;
    end else begin
      if (h_wr_ev)    idr_q <= idr_n;
      if (slv_wr_odr) odr_q <= odr_n;
    end
  end

  assign host_dout = host_a0 ? status : odr_q;
  assign cpu_rdata = cpu_sel ? status : idr_q;
  assign cpu_irq   = ibf;

  // R2
  idr_load_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    h_wr_ev |=> (idr_q == $past(host_din)));
  // R4
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    h_wr_ev |=> cpu_irq);
  // R6
  obf_drop_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (h_rd_ev && !slv_wr_odr) |=> !status[BIT_OBF]);
endmodule

// File: tb/mbx_hostlink_tb_top.sv
`timescale 1ns/1ps
module mbx_hostlink_tb_top;
  localparam int STG = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       host_cs, host_wr, host_rd, host_a0;
  logic [7:0] host_din, host_dout;
  logic       cpu_sel, cpu_we, cpu_re;
  logic [7:0] cpu_wdata, cpu_rdata;
  logic       cpu_irq;

  int checks = 0;
  int failures = 0;
  logic [4:0] m_user;
  logic       m_cd, m_ibf, m_obf;

  always #2.5 clk = ~clk;

  mbx_hostlink #(.SYNC_STAGES(STG)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .host_cs(host_cs), .host_wr(host_wr), .host_rd(host_rd), .host_a0(host_a0),
    .host_din(host_din), .host_dout(host_dout),
    .cpu_sel(cpu_sel), .cpu_we(cpu_we), .cpu_re(cpu_re),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_irq(cpu_irq)
  );

  function automatic logic [7:0] exp_status();
    return {m_user[4:1], m_cd, m_user[0], m_ibf, m_obf};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    host_cs = 1'b1; host_a0 = a; host_din = d; host_wr = 1'b1;
    repeat (STG + 3) @(negedge clk);
    host_wr = 1'b0; host_cs = 1'b0;
    repeat (STG + 2) @(negedge clk);
  endtask

  task automatic host_read(input logic a, output logic [7:0] v);
    @(negedge clk);
    host_cs = 1'b1; host_a0 = a; host_rd = 1'b1;
    @(negedge clk);
    v = host_dout;
    repeat (STG + 3) @(negedge clk);
    host_rd = 1'b0; host_cs = 1'b0;
    repeat (STG + 2) @(negedge clk);
  endtask

  task automatic cpu_read(input logic s, output logic [7:0] v);
    @(negedge clk);
    cpu_sel = s; cpu_re = 1'b1;
    #1 v = cpu_rdata;
    @(negedge clk);
    cpu_re = 1'b0;
  endtask

  task automatic cpu_write(input logic s, input logic [7:0] d);
    @(negedge clk);
    cpu_sel = s; cpu_wdata = d; cpu_we = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic run_all();
    logic [7:0] v;
    // R1 reset state
    cpu_read(1'b1, v);      chk("R1 cpu status", v, 8'h00);
    chk("R1 irq", {7'd0, cpu_irq}, 8'h00);
    host_read(1'b1, v);     chk("R1 host status", v, 8'h00);

    // R2 R3 R4 R9 sweep every byte with both address values
    for (int a = 0; a < 2; a++) begin
      for (int d = 0; d < 256; d++) begin
        host_write(a[0], d[7:0]);
        m_cd = a[0]; m_ibf = 1'b1;
        chk("R4 irq up", {7'd0, cpu_irq}, 8'h01);
        cpu_read(1'b1, v);  chk("R3 R9 status after write", v, exp_status());
        cpu_read(1'b0, v);  chk("R2 inbound byte", v, d[7:0]);
        m_ibf = 1'b0;
        chk("R4 irq down", {7'd0, cpu_irq}, 8'h00);
      end
    end

    // R6 R7 R8 sweep status writes
    for (int d = 0; d < 256; d++) begin
      cpu_write(1'b0, d[7:0]); m_obf = 1'b1;
      host_read(1'b1, v);  chk("R6 status read keeps obf", v, exp_status());
      cpu_write(1'b1, d[7:0]);
      m_user = {d[7:4], d[2]};
      if (!d[0]) m_obf = 1'b0;
      cpu_read(1'b1, v);   chk("R7 R8 status write", v, exp_status());
      host_read(1'b0, v);  chk("R6 outbound byte", v, d[7:0]);
      m_obf = 1'b0;
      cpu_read(1'b1, v);   chk("R6 obf cleared by host", v, exp_status());
    end

    // R7 host writes leave the software bits alone
    cpu_write(1'b1, 8'hA4); m_user = 5'b10101;
    host_write(1'b0, 8'h5A); m_cd = 1'b0; m_ibf = 1'b1;
    host_read(1'b1, v);  chk("R7 host sees user bits", v, exp_status());

    // R5 same-cycle host write and processor read
    @(negedge clk);
    host_cs = 1'b1; host_a0 = 1'b1; host_din = 8'hC3; host_wr = 1'b1;
    repeat (STG) @(posedge clk);
    @(negedge clk);
    cpu_sel = 1'b0; cpu_re = 1'b1;
    @(negedge clk);
    cpu_re = 1'b0;
    m_cd = 1'b1; m_ibf = 1'b1;
    chk("R5 irq kept", {7'd0, cpu_irq}, 8'h01);
    repeat (3) @(negedge clk);
    host_wr = 1'b0; host_cs = 1'b0;
    repeat (STG + 2) @(negedge clk);
    cpu_read(1'b1, v);   chk("R5 status", v, exp_status());
    cpu_read(1'b0, v);   chk("R5 new byte", v, 8'hC3);
    m_ibf = 1'b0;

    // R10 strobes without chip select
    @(negedge clk);
    host_cs = 1'b0; host_a0 = 1'b0; host_din = 8'h11; host_wr = 1'b1;
    repeat (10) @(negedge clk);
    host_wr = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10 no-cs write irq", {7'd0, cpu_irq}, 8'h00);
    cpu_read(1'b0, v);   chk("R10 no-cs write data", v, 8'hC3);
    cpu_write(1'b0, 8'h77); m_obf = 1'b1;
    @(negedge clk);
    host_cs = 1'b0; host_rd = 1'b1;
    repeat (10) @(negedge clk);
    host_rd = 1'b0;
    repeat (4) @(negedge clk);
    cpu_read(1'b1, v);   chk("R10 no-cs read", v, exp_status());

    // R10 held read strobe acts once
    @(negedge clk);
    host_cs = 1'b1; host_a0 = 1'b0; host_rd = 1'b1;
    repeat (STG + 4) @(negedge clk);
    m_obf = 1'b0;
    cpu_write(1'b0, 8'h99); m_obf = 1'b1;
    repeat (8) @(negedge clk);
    cpu_read(1'b1, v);   chk("R10 held read no repeat", v, exp_status());
    chk("R10 held read data", host_dout, 8'h99);
    host_rd = 1'b0; host_cs = 1'b0;
    repeat (STG + 2) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    host_cs = 0; host_wr = 0; host_rd = 0; host_a0 = 0; host_din = 0;
    cpu_sel = 0; cpu_we = 0; cpu_re = 0; cpu_wdata = 0;
    m_user = 0; m_cd = 0; m_ibf = 0; m_obf = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    fork
      run_all();
      begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog R1..R10 actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule